// File: doc/BRIEF.md
# RISC Instruction Decoder and Control Unit

This block turns one 32-bit instruction word into the control bundle of a small integer datapath. It cuts the word into its register, immediate and jump fields, chooses the register that is written, extends the 16-bit immediate the way each instruction needs, and names the ALU operation, the write-back source, the memory access and the change of control flow. It has no clock and no state, so the outputs follow the input word within the same cycle.

It covers seventeen operations. The register-format group is add, subtract, set-less-than and jump-through-register. The immediate group is add, set-less-than, AND, OR and load-upper. The memory group is word and byte loads and stores. Control flow is branch-if-equal, branch-if-not-equal, jump and jump-with-link. Any other word raises an illegal flag and silences every control output. The register file, the ALU and the program-counter logic sit outside and only receive these controls.

Top module: `risc_decode`

## Requirements
- R1: `rs_o` always equals bits [25:21], `rt_o` always equals bits [20:16] and `jtarget_o` always equals bits [25:0], whatever the opcode.
- R2: With opcode 0, funct 32 is add (ALU code 0), 34 is subtract (code 1) and 42 is signed set-less-than (code 2). Each writes a register from the ALU (`wb_sel_o`=0) with `alu_src_imm_o`=0. Funct 8 asserts `jump_reg_o` and writes nothing.
- R3: Register-format writes go to bits [15:11], immediate-format writes go to bits [20:16], and `dest_o` is 0 whenever `reg_we_o` is 0.
- R4: `imm_o` is bits [15:0] zero-extended for opcodes 12 and 13, shifted into the upper half for opcode 15, and sign-extended for every other opcode.
- R5: Opcode 15 (load-upper) gives `imm_o` = {bits[15:0], 16 zeros}, ALU code 5 (pass second operand), `alu_src_imm_o`=1, and a write to bits [20:16].
- R6: Opcode 35 (word load) and opcode 32 (byte load) assert `mem_rd_o`, ALU code 0 with the immediate, `wb_sel_o`=1 and a write. Opcode 43 (word store) and opcode 40 (byte store) assert `mem_wr_o` and do not write a register. `mem_byte_o` is 1 only for 32 and 40.
- R7: Opcode 3 (jump-with-link) asserts `jump_o` and `reg_we_o`, with `dest_o`=31 and `wb_sel_o`=2 (return address).
- R8: Opcode 4 asserts `br_eq_o`, opcode 5 asserts `br_ne_o`, and both use ALU code 1 on registers. Opcode 2 asserts `jump_o`. At most one of the four flow outputs is ever high.
- R9: An opcode outside the listed set, or opcode 0 with a funct outside {8, 32, 34, 42}, sets `illegal_o`. It then drives every control output to 0 (write, memory, flow, `wb_sel_o`, ALU code, operand select, `dest_o`), while the fields and `imm_o` are still presented.
- R10: Opcode 8 (add-immediate, ALU code 0), 10 (set-less-than-immediate, code 2), 12 (AND, code 3) and 13 (OR, code 4) use the immediate operand and write bits [20:16] from the ALU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source register index |
| dest_o | output | 5 | Register written, 0 if none |
| imm_o | output | 32 | Extended immediate |
| jtarget_o | output | 26 | Jump target field |
| alu_op_o | output | 3 | 0 add, 1 sub, 2 slt, 3 and, 4 or, 5 pass B |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| reg_we_o | output | 1 | Register write enable |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 return address |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| mem_byte_o | output | 1 | Access is one byte |
| br_eq_o | output | 1 | Branch when operands equal |
| br_ne_o | output | 1 | Branch when operands differ |
| jump_o | output | 1 | Jump to target field |
| jump_reg_o | output | 1 | Jump to address in rs |
| illegal_o | output | 1 | Word not in the supported set |

## Verification
The bench puts negative immediates on the zero-extending logic operations and positive ones on the sign-extending group. A decoder that swapped the extension rule shows wrong upper bits only for one sign, so both signs are tried. It tries register-format words with unsupported funct values and all 64 opcodes with busy fields, because a design that forgot to clear an enable on an illegal word would issue a spurious write or store. It checks that load-upper leaves the low half zero, that jump-with-link targets register 31 rather than a field of the word, and that stores report no destination even though their rt field is non-zero.

// File: rtl/risc_dec_pkg.sv
package risc_dec_pkg;

    localparam int unsigned OP_W    = 6;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned JT_W    = 26;
    localparam int unsigned FN_W    = 6;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
    localparam logic [OP_W-1:0] OP_J     = 6'd2;
    localparam logic [OP_W-1:0] OP_JAL   = 6'd3;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
    localparam logic [OP_W-1:0] OP_BNE   = 6'd5;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'd8;
    localparam logic [OP_W-1:0] OP_SLTI  = 6'd10;
    localparam logic [OP_W-1:0] OP_ANDI  = 6'd12;
    localparam logic [OP_W-1:0] OP_ORI   = 6'd13;
    localparam logic [OP_W-1:0] OP_LUI   = 6'd15;
    localparam logic [OP_W-1:0] OP_LB    = 6'd32;
    localparam logic [OP_W-1:0] OP_LW    = 6'd35;
    localparam logic [OP_W-1:0] OP_SB    = 6'd40;
    localparam logic [OP_W-1:0] OP_SW    = 6'd43;

    localparam logic [FN_W-1:0] FN_JR    = 6'd8;
    localparam logic [FN_W-1:0] FN_ADD   = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB   = 6'd34;
    localparam logic [FN_W-1:0] FN_SLT   = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_SLT   = 3'd2,
        ALU_AND   = 3'd3,
        ALU_OR    = 3'd4,
        ALU_PASSB = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_sel_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_e;

    typedef struct packed {
        logic     illegal;
        logic     reg_we;
        dst_sel_e dst_sel;
        wb_sel_e  wb_sel;
        alu_op_e  alu_op;
        logic     alu_src_imm;
        logic     mem_rd;
        logic     mem_wr;
        logic     mem_byte;
        logic     br_eq;
        logic     br_ne;
        logic     jump;
        logic     jump_reg;
        ext_e     ext;
    } ctrl_t;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields
    import risc_dec_pkg::*;
#(
    parameter int unsigned IW = 32
) (
    input  logic [IW-1:0]    word_i,
    output logic [OP_W-1:0]  op_o,
    output logic [REG_W-1:0] rs_o,
    output logic [REG_W-1:0] rt_o,
    output logic [REG_W-1:0] rd_o,
    output logic [FN_W-1:0]  fn_o,
    output logic [IMM_W-1:0] imm16_o,
    output logic [JT_W-1:0]  jt_o
);
    localparam int unsigned OP_LSB = IW - OP_W;
    localparam int unsigned RS_LSB = OP_LSB - REG_W;
    localparam int unsigned RT_LSB = RS_LSB - REG_W;
    localparam int unsigned RD_LSB = RT_LSB - REG_W;

    always_comb begin
        op_o    = word_i[IW-1:OP_LSB];
        rs_o    = word_i[RS_LSB +: REG_W];
        rt_o    = word_i[RT_LSB +: REG_W];
        rd_o    = word_i[RD_LSB +: REG_W];
        fn_o    = word_i[FN_W-1:0];
        imm16_o = word_i[IMM_W-1:0];
        jt_o    = word_i[JT_W-1:0];
    end
endmodule

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
    import risc_dec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output ctrl_t           ctrl_o
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.alu_op   = ALU_ADD;
        ctrl_d.wb_sel   = WB_ALU;
        ctrl_d.dst_sel  = DST_NONE;
        ctrl_d.ext      = EXT_SIGN;

        case (op_i)
            OP_RTYPE: begin
                case (fn_i)
                    FN_ADD: begin
                        ctrl_d.reg_we  = 1'b1;
                        ctrl_d.dst_sel = DST_RD;
                    end
                    FN_SUB: begin
                        ctrl_d.reg_we  = 1'b1;
                        ctrl_d.dst_sel = DST_RD;
                        ctrl_d.alu_op  = ALU_SUB;
                    end
                    FN_SLT: begin
                        ctrl_d.reg_we  = 1'b1;
                        ctrl_d.dst_sel = DST_RD;
                        ctrl_d.alu_op  = ALU_SLT;
                    end
                    FN_JR:   ctrl_d.jump_reg = 1'b1;
                    default: ctrl_d.illegal  = 1'b1;
                endcase
            end
            OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_LUI: begin
                ctrl_d.reg_we      = 1'b1;
                ctrl_d.dst_sel     = DST_RT;
                ctrl_d.alu_src_imm = 1'b1;
                case (op_i)
                    OP_SLTI: ctrl_d.alu_op = ALU_SLT;
                    OP_ANDI: begin
                        ctrl_d.alu_op = ALU_AND;
                        ctrl_d.ext    = EXT_ZERO;
                    end
                    OP_ORI: begin
                        ctrl_d.alu_op = ALU_OR;
                        ctrl_d.ext    = EXT_ZERO;
                    end
                    OP_LUI: begin
                        ctrl_d.alu_op = ALU_PASSB;
                        ctrl_d.ext    = EXT_UPPER;
                    end
                    default: ctrl_d.alu_op = ALU_ADD;
                endcase
            end
            OP_LW, OP_LB: begin
                ctrl_d.reg_we      = 1'b1;
                ctrl_d.dst_sel     = DST_RT;
                ctrl_d.alu_src_imm = 1'b1;
                ctrl_d.mem_rd      = 1'b1;
                ctrl_d.wb_sel      = WB_MEM;
                ctrl_d.mem_byte    = (op_i == OP_LB);
            end
            OP_SW, OP_SB: begin
                ctrl_d.alu_src_imm = 1'b1;
                ctrl_d.mem_wr      = 1'b1;
                ctrl_d.mem_byte    = (op_i == OP_SB);
            end
            OP_BEQ: begin
                ctrl_d.br_eq  = 1'b1;
                ctrl_d.alu_op = ALU_SUB;
            end
            OP_BNE: begin
                ctrl_d.br_ne  = 1'b1;
                ctrl_d.alu_op = ALU_SUB;
            end
            OP_J:   ctrl_d.jump = 1'b1;
            OP_JAL: begin
                ctrl_d.jump    = 1'b1;
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.dst_sel = DST_LINK;
                ctrl_d.wb_sel  = WB_LINK;
            end
            default: ctrl_d.illegal = 1'b1;
        endcase

        if (ctrl_d.illegal) begin
            ctrl_d         = '0;
            ctrl_d.illegal = 1'b1;
            ctrl_d.ext     = EXT_SIGN;
        end
    end

    assign ctrl_o = ctrl_d;
endmodule

// File: rtl/rdec_immext.sv
module rdec_immext
    import risc_dec_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [IMM_W-1:0] imm16_i,
    input  ext_e             ext_i,
    output logic [XLEN-1:0]  imm_o
);
    localparam int unsigned PAD_W = XLEN - IMM_W;

    always_comb begin
        case (ext_i)
            EXT_ZERO:  imm_o = {{PAD_W{1'b0}}, imm16_i};
            EXT_UPPER: imm_o = {imm16_i, {PAD_W{1'b0}}};
            default:   imm_o = {{PAD_W{imm16_i[IMM_W-1]}}, imm16_i};
        endcase
    end
endmodule

// File: rtl/risc_decode.sv
module risc_decode
    import risc_dec_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned LINK_REG = 31
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rs_o,
    output logic [4:0]      rt_o,
    output logic [4:0]      dest_o,
    output logic [XLEN-1:0] imm_o,
    output logic [25:0]     jtarget_o,
    output logic [2:0]      alu_op_o,
    output logic            alu_src_imm_o,
    output logic            reg_we_o,
    output logic [1:0]      wb_sel_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            mem_byte_o,
    output logic            br_eq_o,
    output logic            br_ne_o,
    output logic            jump_o,
    output logic            jump_reg_o,
    output logic            illegal_o
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    logic [OP_W-1:0]  op_w;
    logic [REG_W-1:0] rd_w;
    logic [FN_W-1:0]  fn_w;
    logic [IMM_W-1:0] imm16_w;
    ctrl_t            ctrl_w;

    rdec_fields #(.IW(32)) u_fields (
        .word_i  (instr_i),
        .op_o    (op_w),
        .rs_o    (rs_o),
        .rt_o    (rt_o),
        .rd_o    (rd_w),
        .fn_o    (fn_w),
        .imm16_o (imm16_w),
        .jt_o    (jtarget_o)
    );

    rdec_ctrl u_ctrl (
        .op_i   (op_w),
        .fn_i   (fn_w),
        .ctrl_o (ctrl_w)
    );

    rdec_immext #(.XLEN(XLEN)) u_imm (
        .imm16_i (imm16_w),
        .ext_i   (ctrl_w.ext),
        .imm_o   (imm_o)
    );

    always_comb begin
        case (ctrl_w.dst_sel)
            DST_RD:   dest_o = rd_w;
            DST_RT:   dest_o = rt_o;
            DST_LINK: dest_o = LINK_IDX;
            default:  dest_o = '0;
        endcase
    end

    assign alu_op_o      = ctrl_w.alu_op;
    assign alu_src_imm_o = ctrl_w.alu_src_imm;
    assign reg_we_o      = ctrl_w.reg_we;
    assign wb_sel_o      = ctrl_w.wb_sel;
    assign mem_rd_o      = ctrl_w.mem_rd;
    assign mem_wr_o      = ctrl_w.mem_wr;
    assign mem_byte_o    = ctrl_w.mem_byte;
    assign br_eq_o       = ctrl_w.br_eq;
    assign br_ne_o       = ctrl_w.br_ne;
    assign jump_o        = ctrl_w.jump;
    assign jump_reg_o    = ctrl_w.jump_reg;
    assign illegal_o     = ctrl_w.illegal;
endmodule

// File: rtl/risc_decode_chk.sv
module risc_decode_chk (
    input logic [5:0]  op_i,
    input logic [4:0]  dest_i,
    input logic [15:0] imm_lo_i,
    input logic        reg_we_i,
    input logic        mem_rd_i,
    input logic        mem_wr_i,
    input logic        br_eq_i,
    input logic        br_ne_i,
    input logic        jump_i,
    input logic        jump_reg_i,
    input logic [1:0]  wb_sel_i,
    input logic        illegal_i
);
    always_comb begin
        if (!$isunknown(op_i)) begin
            AST_ILLEGAL_QUIET: assert (!illegal_i || (!reg_we_i && !mem_rd_i && !mem_wr_i && !jump_i && !jump_reg_i)) else $error("illegal word left an enable high"); // R9
            AST_MEM_EXCL: assert (!(mem_rd_i && mem_wr_i)) else $error("load and store together"); // R6
            AST_LINK_DEST: assert (wb_sel_i != 2'd2 || (reg_we_i && dest_i == 5'd31 && jump_i)) else $error("link write not to register 31"); // R7
            AST_LUI_LOW_ZERO: assert (op_i != 6'd15 || imm_lo_i == 16'h0) else $error("load-upper low half not zero"); // R5
            AST_FLOW_ONEHOT: assert ($onehot0({br_eq_i, br_ne_i, jump_i, jump_reg_i})) else $error("several flow controls"); // R8
            AST_DEST_QUIET: assert (reg_we_i || dest_i == 5'd0) else $error("destination without write"); // R3
        end
    end
endmodule

bind risc_decode risc_decode_chk u_chk (
    .op_i       (instr_i[31:26]),
    .dest_i     (dest_o),
    .imm_lo_i   (imm_o[15:0]),
    .reg_we_i   (reg_we_o),
    .mem_rd_i   (mem_rd_o),
    .mem_wr_i   (mem_wr_o),
    .br_eq_i    (br_eq_o),
    .br_ne_i    (br_ne_o),
    .jump_i     (jump_o),
    .jump_reg_i (jump_reg_o),
    .wb_sel_i   (wb_sel_o),
    .illegal_i  (illegal_o)
);

// File: tb/risc_decode_tb.sv
module risc_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    logic [4:0]  rs, rt, dest;
    logic [31:0] imm;
    logic [25:0] jt;
    logic [2:0]  alu_op;
    logic [1:0]  wb_sel;
    logic        src_imm, we, mrd, mwr, mby, beq, bne, jmp, jr, ill;

    always #5 clk = ~clk;

    risc_decode u_dut (
        .instr_i       (instr),
        .rs_o          (rs),
        .rt_o          (rt),
        .dest_o        (dest),
        .imm_o         (imm),
        .jtarget_o     (jt),
        .alu_op_o      (alu_op),
        .alu_src_imm_o (src_imm),
        .reg_we_o      (we),
        .wb_sel_o      (wb_sel),
        .mem_rd_o      (mrd),
        .mem_wr_o      (mwr),
        .mem_byte_o    (mby),
        .br_eq_o       (beq),
        .br_ne_o       (bne),
        .jump_o        (jmp),
        .jump_reg_o    (jr),
        .illegal_o     (ill)
    );

    function automatic logic [87:0] ref_model(input logic [31:0] w);
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        logic e_ill = 0, e_we = 0, e_src = 0, e_mrd = 0, e_mwr = 0, e_mby = 0;
        logic e_beq = 0, e_bne = 0, e_jmp = 0, e_jr = 0;
        logic [4:0]  e_dst = 0;
        logic [1:0]  e_wb = 0;
        logic [2:0]  e_alu = 0;
        logic [31:0] e_imm = {{16{w[15]}}, w[15:0]};
        case (op)
            0: begin
                if (fn == 32 || fn == 34 || fn == 42) begin
                    e_we = 1; e_dst = w[15:11];
                    e_alu = (fn == 32) ? 3'd0 : (fn == 34) ? 3'd1 : 3'd2;
                end else if (fn == 8) e_jr = 1;
                else e_ill = 1;
            end
            8, 10, 12, 13, 15: begin
                e_we = 1; e_dst = w[20:16]; e_src = 1;
                if (op == 10) e_alu = 2;
                if (op == 12) begin e_alu = 3; e_imm = {16'h0, w[15:0]}; end
                if (op == 13) begin e_alu = 4; e_imm = {16'h0, w[15:0]}; end
                if (op == 15) begin e_alu = 5; e_imm = {w[15:0], 16'h0}; end
            end
            35, 32: begin
                e_we = 1; e_dst = w[20:16]; e_src = 1; e_mrd = 1; e_wb = 1;
                e_mby = (op == 32);
            end
            43, 40: begin
                e_src = 1; e_mwr = 1; e_mby = (op == 40);
            end
            4: begin e_beq = 1; e_alu = 1; end
            5: begin e_bne = 1; e_alu = 1; end
            2: e_jmp = 1;
            3: begin e_jmp = 1; e_we = 1; e_dst = 5'd31; e_wb = 2; end
            default: e_ill = 1;
        endcase
        return {e_ill, e_we, e_dst, e_wb, e_alu, e_src, e_mrd, e_mwr, e_mby,
                e_beq, e_bne, e_jmp, e_jr, e_imm, w[25:21], w[20:16], w[25:0]};
    endfunction

    task automatic apply(input logic [31:0] w, input string req);
        logic [87:0] act, exp_v;
        @(negedge clk);
        instr = w;
        #1;
        act = {ill, we, dest, wb_sel, alu_op, src_imm, mrd, mwr, mby,
               beq, bne, jmp, jr, imm, rs, rt, jt};
        exp_v = ref_model(w);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s instr=%h act=%h exp=%h", req, w, act, exp_v);
        end
    endtask

    function automatic logic [31:0] mk_r(int rs_v, int rt_v, int rd_v, int fn);
        return {6'd0, 5'(rs_v), 5'(rt_v), 5'(rd_v), 5'd7, 6'(fn)};
    endfunction

    function automatic logic [31:0] mk_i(int op, int rs_v, int rt_v, logic [15:0] k);
        return {6'(op), 5'(rs_v), 5'(rt_v), k};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'hACE1_2357;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset-time word: all zero is unsupported funct 0 (R9)
        apply(32'h0, "R9");
        // R1 R2 register-format group
        apply(mk_r(3, 4, 9, 32), "R2");
        apply(mk_r(17, 18, 8, 34), "R2");
        apply(mk_r(31, 1, 30, 42), "R2");
        apply(mk_r(31, 0, 0, 8), "R2");
        apply(mk_r(5, 6, 7, 33), "R9");
        apply(mk_r(5, 6, 7, 36), "R9");
        // R10 R4 immediate arithmetic, both immediate signs
        apply(mk_i(8, 2, 12, 16'hFFF0), "R10");
        apply(mk_i(8, 2, 12, 16'h0123), "R4");
        apply(mk_i(10, 9, 1, 16'h8000), "R10");
        apply(mk_i(12, 9, 14, 16'hF00F), "R4");
        apply(mk_i(13, 9, 14, 16'h8001), "R4");
        // R5 load-upper
        apply(mk_i(15, 0, 8, 16'hAAAA), "R5");
        apply(mk_i(15, 7, 8, 16'h003D), "R5");
        // R6 memory
        apply(mk_i(35, 19, 8, 16'd32), "R6");
        apply(mk_i(32, 29, 10, 16'hFFFC), "R6");
        apply(mk_i(43, 19, 8, 16'd48), "R6");
        apply(mk_i(40, 28, 10, 16'h8000), "R6");
        // R8 flow, R7 link, R3 destination on store and branch
        apply(mk_i(4, 16, 17, 16'hFFFF), "R8");
        apply(mk_i(5, 8, 21, 16'd2), "R8");
        apply({6'd2, 26'd20000}, "R8");
        apply({6'd3, 26'h3FF_FFFF}, "R7");
        apply({6'd3, 5'd7, 21'h0}, "R7");
        // R1 fields on a jump word with busy bits
        apply({6'd2, 26'h2AB_CDEF}, "R1");
        // R9 illegal opcodes
        apply(mk_i(1, 3, 4, 16'h1234), "R9");
        apply(mk_i(9, 3, 4, 16'h1234), "R9");
        apply(mk_i(63, 31, 31, 16'hFFFF), "R9");
        // R3 R9 sweep every opcode and every funct with busy fields
        for (int o = 0; o < 64; o++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply({6'(o), lfsr[25:0]}, "R3");
        end
        for (int f = 0; f < 64; f++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply({6'd0, lfsr[25:6], 6'(f)}, "R9");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule